// File: doc/BRIEF.md
# Byte ALU with Stored Condition Flags

This block is the arithmetic core of a small 8-bit processor datapath. A combinational unit takes two byte operands and a 4-bit operation code. It returns a byte result in the same cycle. The carry input for the carry-chained operations comes from the carry bit the block already holds, so multi-byte arithmetic chains from one operation to the next.

Beside the arithmetic unit sits an 8-bit flag register. On the next clock edge after an operation is presented with `op_valid` high, the flags that operation defines are written: overflow, half-carry, negative, zero and carry. All other flags keep their value. The same register also holds the interrupt mask bit. Interrupt handling itself is not part of this block, so that bit only changes through a direct load of the whole register.

The operations are add and subtract, each with or without the stored carry, the bitwise AND, OR and XOR, four shifts and rotates through carry, a nibble exchange, and a decimal-adjust step. The decimal-adjust step fixes up a byte after a binary add of two packed BCD values.

Top module: `alu_ccr_unit`

## Requirements
- R1: The flag register layout from bit 7 down to bit 0 is V, 1, 1, H, I, N, Z, C. Bits 6 and 5 always read 1. Asynchronous reset (`rst_n` low) gives 0x68, which means I=1 and every other flag is 0.
- R2: `op_sel` 0 is add (A+B) and 1 is add with the stored carry (A+B+C). C receives the carry out of bit 7. H receives the carry from bit 3 into bit 4. V receives the two's-complement overflow.
- R3: `op_sel` 2 is subtract (A−B) and 3 is subtract with the stored carry (A−B−C). C receives the borrow and V the two's-complement overflow. H is left unchanged.
- R4: For every operation that writes flags (codes 0–11 and 13), N receives result bit 7, and Z is 1 exactly when the result is 0x00.
- R5: `op_sel` 4, 5 and 6 are AND, OR and XOR. They clear V and leave H and C unchanged.
- R6: The shifts and rotates are: code 7 shifts left and inserts 0; code 8 shifts right logically and inserts 0; code 9 shifts right arithmetically and keeps bit 7; code 10 rotates left through C; code 11 rotates right through C. C receives the bit shifted out, and V receives the new N XOR the new C. H is unchanged.
- R7: `op_sel` 12 exchanges the upper and lower nibbles of A. It changes no flag.
- R8: `op_sel` 13 is the decimal adjust of A. It adds 0x06 when H=1 or A[3:0]>9. It then adds 0x60 when C=1, when the first add carried out of bit 7, or when the upper digit after the first add exceeds 9. C is set whenever 0x60 is added and is never cleared. V and H are unchanged.
- R9: Flags change only on a clock edge at which `op_valid` or `ccr_load` is high. Codes 14 and 15 return A and change no flag.
- R10: When `ccr_load` is high, the next edge writes `ccr_wdata` into the register with bits 6 and 5 forced to 1. This takes priority over `op_valid`.
- R11: `result` is combinational from `op_sel`, the operands and the stored C. It is valid in the same cycle, while the flags appear after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Commit the flags of the current operation at the next edge |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | First operand (accumulator side) |
| opnd_b | input | 8 | Second operand |
| ccr_load | input | 1 | Load the flag register from `ccr_wdata` |
| ccr_wdata | input | 8 | Value for a flag register load |
| result | output | 8 | Operation result |
| ccr_q | output | 8 | Flag register contents |

## Verification
The result is due in the same cycle the operands and code are driven, with zero register stages, and it depends on the carry held before the next edge. The flags are due one edge later. The driver applies each operation at a falling edge and queues its expected result and flag value. The monitor compares the result a quarter period after that falling edge, before the flag register can move. It then compares the flags a quarter period after the following rising edge. Random operations are interleaved with random register loads, so every operation is exercised with both carry-in values and both half-carry values.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W  = 8;
    localparam int NIB_W   = DATA_W / 2;

    // flag register bit positions (fixed layout)
    localparam int F_V = 7;
    localparam int F_H = 4;
    localparam int F_I = 3;
    localparam int F_N = 2;
    localparam int F_Z = 1;
    localparam int F_C = 0;

    localparam logic [7:0] CCR_ONES  = 8'h60;
    localparam logic [7:0] CCR_RESET = 8'h68;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SHL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_SAR  = 4'd9,
        OP_RCL  = 4'd10,
        OP_RCR  = 4'd11,
        OP_SWAP = 4'd12,
        OP_DADJ = 4'd13,
        OP_PASS = 4'd14,
        OP_NOP  = 4'd15
    } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    input  logic         use_cin,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    localparam int HW = W / 2;

    logic [W-1:0]  bx;
    logic          cx;
    logic [W:0]    sum;
    logic [HW:0]   lo;

    always_comb begin
        bx    = sub ? ~b : b;
        cx    = use_cin ? (sub ? ~cin : cin) : sub;
        sum   = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cx};
        lo    = {1'b0, a[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, cx};
        res   = sum[W-1:0];
        c_out = sum[W] ^ sub;
        h_out = lo[HW];
        v_out = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         c_out
);
    localparam int HW = W / 2;

    always_comb begin
        res   = a;
        c_out = cin;
        unique case (op)
            OP_SHL: begin
                res   = {a[W-2:0], 1'b0};
                c_out = a[W-1];
            end
            OP_SHR: begin
                res   = {1'b0, a[W-1:1]};
                c_out = a[0];
            end
            OP_SAR: begin
                res   = {a[W-1], a[W-1:1]};
                c_out = a[0];
            end
            OP_RCL: begin
                res   = {a[W-2:0], cin};
                c_out = a[W-1];
            end
            OP_RCR: begin
                res   = {cin, a[W-1:1]};
                c_out = a[0];
            end
            OP_SWAP: begin
                res   = {a[HW-1:0], a[W-1:HW]};
                c_out = cin;
            end
            default: begin
                res   = a;
                c_out = cin;
            end
        endcase
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu_bcd.sv
module alu_bcd
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic         h_in,
    input  logic         c_in,
    output logic [W-1:0] res,
    output logic         c_out
);
    localparam int HW = W / 2;
    localparam logic [HW-1:0] DIGIT_MAX = HW'(9);
    localparam logic [W:0]    LO_FIX    = (W+1)'(6);
    localparam logic [W-1:0]  HI_FIX    = W'(6) << HW;

    logic          lo_fix;
    logic          hi_fix;
    logic [W:0]    t1;

    always_comb begin
        lo_fix = h_in || (a[HW-1:0] > DIGIT_MAX);
        t1     = {1'b0, a} + (lo_fix ? LO_FIX : '0);
        hi_fix = c_in || t1[W] || (t1[W-1:HW] > DIGIT_MAX);
        res    = t1[W-1:0] + (hi_fix ? HI_FIX : '0);
        c_out  = c_in | hi_fix;
    end
endmodule

// File: rtl/alu_ccr_unit.sv
module alu_ccr_unit
    import alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [3:0] op_sel,
    input  logic [7:0] opnd_a,
    input  logic [7:0] opnd_b,
    input  logic       ccr_load,
    input  logic [7:0] ccr_wdata,
    output logic [7:0] result,
    output logic [7:0] ccr_q
);
    alu_op_e     op;
    logic [7:0]  ccr_r;

    logic [7:0]  as_res, lg_res, sh_res, bcd_res;
    logic        as_c, as_h, as_v, sh_c, bcd_c;
    logic        is_sub, use_cin;

    logic [7:0]  alu_res;
    logic        we_v, we_h, we_c, we_nz;
    logic        nv, nh, nc;
    logic [7:0]  ccr_next;

    assign op      = alu_op_e'(op_sel);
    assign is_sub  = (op == OP_SUB) || (op == OP_SBC);
    assign use_cin = (op == OP_ADC) || (op == OP_SBC);

    alu_addsub #(.W(DATA_W)) i_addsub (
        .a(opnd_a), .b(opnd_b), .cin(ccr_r[F_C]), .sub(is_sub), .use_cin(use_cin),
        .res(as_res), .c_out(as_c), .h_out(as_h), .v_out(as_v)
    );

    alu_logic #(.W(DATA_W)) i_logic (
        .op(op), .a(opnd_a), .b(opnd_b), .res(lg_res)
    );

    alu_shift #(.W(DATA_W)) i_shift (
        .op(op), .a(opnd_a), .cin(ccr_r[F_C]), .res(sh_res), .c_out(sh_c)
    );

    alu_bcd #(.W(DATA_W)) i_bcd (
        .a(opnd_a), .h_in(ccr_r[F_H]), .c_in(ccr_r[F_C]), .res(bcd_res), .c_out(bcd_c)
    );

    // result select and flag write enables
    always_comb begin
        alu_res = opnd_a;
        we_v = 1'b0; we_h = 1'b0; we_c = 1'b0; we_nz = 1'b0;
        nv = 1'b0;   nh = 1'b0;   nc = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                alu_res = as_res;
                we_v = 1'b1; we_h = 1'b1; we_c = 1'b1; we_nz = 1'b1;
                nv = as_v;   nh = as_h;   nc = as_c;
            end
            OP_SUB, OP_SBC: begin
                alu_res = as_res;
                we_v = 1'b1; we_c = 1'b1; we_nz = 1'b1;
                nv = as_v;   nc = as_c;
            end
            OP_AND, OP_OR, OP_XOR: begin
                alu_res = lg_res;
                we_v = 1'b1; we_nz = 1'b1;
                nv = 1'b0;
            end
            OP_SHL, OP_SHR, OP_SAR, OP_RCL, OP_RCR: begin
                alu_res = sh_res;
                we_v = 1'b1; we_c = 1'b1; we_nz = 1'b1;
                nc = sh_c;
                nv = sh_res[DATA_W-1] ^ sh_c;
            end
            OP_SWAP: begin
                alu_res = sh_res;
            end
            OP_DADJ: begin
                alu_res = bcd_res;
                we_c = 1'b1; we_nz = 1'b1;
                nc = bcd_c;
            end
            default: begin
                alu_res = opnd_a;
            end
        endcase
    end

    always_comb begin
        ccr_next = ccr_r;
        if (ccr_load) begin
            ccr_next = ccr_wdata | CCR_ONES;
        end else if (op_valid) begin
            if (we_v)  ccr_next[F_V] = nv;
            if (we_h)  ccr_next[F_H] = nh;
            if (we_c)  ccr_next[F_C] = nc;
            if (we_nz) begin
                ccr_next[F_N] = alu_res[DATA_W-1];
                ccr_next[F_Z] = (alu_res == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ccr_r <= CCR_RESET;
        else        ccr_r <= ccr_next;
    end

    assign result = alu_res;
    assign ccr_q  = ccr_r;

endmodule

// File: rtl/alu_ccr_checker.sv
module alu_ccr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [3:0] op_sel,
    input logic       ccr_load,
    input logic [7:0] ccr_wdata,
    input logic [7:0] result,
    input logic [7:0] ccr_q
);
    logic flag_op;
    logic logic_op;
    logic shift_op;
    assign flag_op  = op_valid && !ccr_load && (op_sel <= 4'd11 || op_sel == 4'd13);
    assign logic_op = op_valid && !ccr_load && (op_sel >= 4'd4 && op_sel <= 4'd6);
    assign shift_op = op_valid && !ccr_load && (op_sel >= 4'd7 && op_sel <= 4'd11);

    // R1: fixed ones
    p_fixed_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_q[6:5] == 2'b11);

    // R9: idle keeps flags
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !ccr_load) |=> $stable(ccr_q));

    // R10: load value
    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_load |=> ccr_q == ($past(ccr_wdata) | 8'h60));

    // R4: zero flag follows result
    p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_op |=> ccr_q[1] == ($past(result) == 8'h00) && ccr_q[2] == $past(result[7]));

    // R5: logic ops keep H and C, clear V
    p_logic_r5: assert property (@(posedge clk) disable iff (!rst_n)
        logic_op |=> !ccr_q[7] && ccr_q[4] == $past(ccr_q[4]) && ccr_q[0] == $past(ccr_q[0]));

    // R6: shift overflow equals N xor C
    p_shift_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_op |=> ccr_q[7] == (ccr_q[2] ^ ccr_q[0]));

    // R8: decimal adjust never clears C
    p_dadj_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !ccr_load && op_sel == 4'd13 && ccr_q[0]) |=> ccr_q[0]);

    // R7: nibble swap changes no flag
    p_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !ccr_load && op_sel == 4'd12) |=> $stable(ccr_q));
endmodule

bind alu_ccr_unit alu_ccr_checker i_alu_ccr_checker (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .ccr_load(ccr_load), .ccr_wdata(ccr_wdata), .result(result), .ccr_q(ccr_q)
);

// File: tb/test_alu_ccr_unit.sv
module test_alu_ccr_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_sel = 4'd15;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic       ccr_load = 1'b0;
    logic [7:0] ccr_wdata = 8'h00;
    logic [7:0] result;
    logic [7:0] ccr_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [7:0] exp_res;
        logic [7:0] exp_ccr;
        logic       chk_res;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];
    logic [7:0] model_ccr;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_ccr_unit i_alu_ccr_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .ccr_load(ccr_load), .ccr_wdata(ccr_wdata),
        .result(result), .ccr_q(ccr_q)
    );

    function automatic int sx(input logic [7:0] x);
        return (x > 8'd127) ? int'(x) - 256 : int'(x);
    endfunction

    // reference: returns {result, next flags}
    function automatic logic [15:0] ref_op(input logic [3:0] op, input logic [7:0] a,
                                           input logic [7:0] b, input logic [7:0] f);
        logic [7:0] r;
        logic v, h, c, n, z;
        int ci, s, sv, t;
        bit nz_upd;
        v = f[7]; h = f[4]; c = f[0]; n = f[2]; z = f[1];
        ci = (op == 4'd1 || op == 4'd3) ? int'(f[0]) : 0;
        r = a;
        nz_upd = 1'b1;
        case (op)
            4'd0, 4'd1: begin
                s = int'(a) + int'(b) + ci;
                r = s[7:0]; c = (s > 255);
                h = ((int'(a) % 16) + (int'(b) % 16) + ci) > 15;
                sv = sx(a) + sx(b) + ci; v = (sv > 127) || (sv < -128);
            end
            4'd2, 4'd3: begin
                s = int'(a) - int'(b) - ci;
                r = s[7:0]; c = (s < 0);
                sv = sx(a) - sx(b) - ci; v = (sv > 127) || (sv < -128);
            end
            4'd4: begin r = a & b; v = 1'b0; end
            4'd5: begin r = a | b; v = 1'b0; end
            4'd6: begin r = a ^ b; v = 1'b0; end
            4'd7:  begin r = a << 1; c = a[7]; v = r[7] ^ c; end
            4'd8:  begin r = a >> 1; c = a[0]; v = r[7] ^ c; end
            4'd9:  begin r = (a >> 1) | (a & 8'h80); c = a[0]; v = r[7] ^ c; end
            4'd10: begin r = (a << 1) | {7'd0, f[0]}; c = a[7]; v = r[7] ^ c; end
            4'd11: begin r = (a >> 1) | {f[0], 7'd0}; c = a[0]; v = r[7] ^ c; end
            4'd12: begin r = {a[3:0], a[7:4]}; nz_upd = 1'b0; end
            4'd13: begin
                t = int'(a);
                if (h || (int'(a) % 16) > 9) t = t + 6;
                if (c || (t / 16) > 9) begin t = t + 96; c = 1'b1; end
                r = t[7:0];
            end
            default: begin r = a; nz_upd = 1'b0; end
        endcase
        if (nz_upd) begin n = r[7]; z = (r == 8'h00); end
        return {r, v, 2'b11, h, f[3], n, z, c};
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        if (op <= 4'd1) return "R2 add";
        if (op <= 4'd3) return "R3 sub";
        if (op <= 4'd6) return "R5 logic";
        if (op <= 4'd11) return "R6 shift";
        if (op == 4'd12) return "R7 swap";
        if (op == 4'd13) return "R8 decadj";
        return "R9 pass";
    endfunction

    // driver: applies one cycle of stimulus and queues the expectation
    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic valid, input logic load, input logic [7:0] wd,
                         input string tag);
        item_t it;
        logic [15:0] m;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        op_valid = valid; ccr_load = load; ccr_wdata = wd;
        m = ref_op(op, a, b, model_ccr);
        it.exp_res = m[15:8];
        it.chk_res = !load;
        if (load)       it.exp_ccr = wd | 8'h60;
        else if (valid) it.exp_ccr = m[7:0];
        else            it.exp_ccr = model_ccr;
        model_ccr = it.exp_ccr;
        exp_q.push_back(it);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 1'b0; ccr_load = 1'b0;
    endtask

    // monitor: result before the edge, flags after it
    initial begin
        item_t it;
        string tg;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                if (it.chk_res) begin
                    checks++;
                    if (result !== it.exp_res) begin
                        errors++;
                        $display("FAIL %s R11 result: actual %02h expected %02h", tg, result, it.exp_res);
                    end
                end
                @(posedge clk);
                #(CLK_PERIOD/4);
                checks++;
                if (ccr_q !== it.exp_ccr) begin
                    errors++;
                    $display("FAIL %s flags: actual %02h expected %02h", tg, ccr_q, it.exp_ccr);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_ccr = 8'h68;
        repeat (3) @(negedge clk);
        checks++;
        if (ccr_q !== 8'h68) begin
            errors++;
            $display("FAIL R1 reset: actual %02h expected 68", ccr_q);
        end
        rst_n = 1'b1;

        // R10/R1: load zero, bits 6:5 forced
        drive(4'd15, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, "R10 R1 load zero");
        drive(4'd0, 8'h08, 8'h08, 1'b1, 1'b0, 8'h00, "R2 half carry");
        drive(4'd0, 8'h7F, 8'h01, 1'b1, 1'b0, 8'h00, "R2 overflow");
        drive(4'd0, 8'hFF, 8'h01, 1'b1, 1'b0, 8'h00, "R2 R4 carry zero");
        drive(4'd1, 8'h10, 8'h20, 1'b1, 1'b0, 8'h00, "R2 adc carry in");
        drive(4'd2, 8'h00, 8'h01, 1'b1, 1'b0, 8'h00, "R3 borrow");
        drive(4'd3, 8'h05, 8'h02, 1'b1, 1'b0, 8'h00, "R3 sbc borrow in");
        drive(4'd2, 8'h80, 8'h01, 1'b1, 1'b0, 8'h00, "R3 overflow");
        drive(4'd15, 8'h00, 8'h00, 1'b0, 1'b1, 8'h11, "R10 load H C");
        drive(4'd4, 8'hF0, 8'h0F, 1'b1, 1'b0, 8'h00, "R5 and zero keeps H C");
        drive(4'd6, 8'hFF, 8'h01, 1'b1, 1'b0, 8'h00, "R5 xor");
        drive(4'd10, 8'h80, 8'h00, 1'b1, 1'b0, 8'h00, "R6 rol");
        drive(4'd11, 8'h01, 8'h00, 1'b1, 1'b0, 8'h00, "R6 ror");
        drive(4'd9, 8'h81, 8'h00, 1'b1, 1'b0, 8'h00, "R6 asr");
        drive(4'd12, 8'hA5, 8'h00, 1'b1, 1'b0, 8'h00, "R7 swap");
        drive(4'd15, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, "R10 clear");
        drive(4'd0, 8'h19, 8'h28, 1'b1, 1'b0, 8'h00, "R2 bcd add");
        drive(4'd13, 8'h41, 8'h00, 1'b1, 1'b0, 8'h00, "R8 decadj low");
        drive(4'd13, 8'hFA, 8'h00, 1'b1, 1'b0, 8'h00, "R8 decadj wrap");
        drive(4'd13, 8'h12, 8'h00, 1'b1, 1'b0, 8'h00, "R8 decadj keeps C");
        drive(4'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, "R9 invalid ignored");
        drive(4'd14, 8'h3C, 8'h00, 1'b1, 1'b0, 8'h00, "R9 pass code");
        drive(4'd0, 8'h01, 8'h01, 1'b1, 1'b1, 8'h00, "R10 load wins");

        for (int i = 0; i < 1200; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0)
                drive(4'd15, 8'h00, 8'h00, 1'b0, 1'b1, 8'($urandom), "R10 random load");
            drive(op, 8'($urandom), 8'($urandom), 1'b1, 1'b0, 8'h00, op_tag(op));
        end

        idle();
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule